// File: doc/BRIEF.md
# MDIO Management Master

This block is a serial management master for Ethernet PHYs. Host software programs a small word-addressed register set. The block then runs one management frame on the two-wire MDC/MDIO pair. A frame either writes a 16-bit value into a PHY register or reads one back. MDC is produced by an even divider of the system clock. The bidirectional data line is split into an output, an output enable and an input, so the pad logic sits outside the block. An optional preamble of 32 ones goes ahead of each frame.

Software polls a busy flag in the status word until the transaction ends, then writes zero to the command word. A command launches only when one of its bits goes from 0 to 1. A link monitor mode reads PHY register 1 over and over. It reports the link as failed when bit 2 of that register is clear, and shows an invalid flag until the first result has arrived.

Top module: `mdio_master`

## Requirements
- R1: After reset, the registers read back as follows: mode holds the reset divider (20, preamble on), command is 0, status is 0 and received data is 0. MDIO is not driven.
- R2: MDC has a period of 2*max(1, d[7:1]) clocks, where d is mode bits 7:0. Bit 0 of d has no effect, so every ratio is even.
- R3: Each frame sends, MSB first, the start code 01, then the opcode (10 for read, 01 for write), then the PHY address from address bits 4:0, then the register number from address bits 12:8. When preamble is enabled, 32 driven ones come before the start code.
- R4: Setting mode bit 8 removes the preamble, so the start code is the first driven bit.
- R5: A write frame sends turnaround 10 and then bits 15:0 of the transmit data word. MDIO is released once the frame ends.
- R6: A read frame releases MDIO from the first turnaround bit onward. It samples 16 data bits on MDC rising edges and places them in bits 15:0 of the receive data word. That word changes only when a read completes.
- R7: MDIO output data and its enable change only on an MDC falling edge.
- R8: Status bit 1 (busy) reads 1 from the cycle after a launching command write until the frame has ended.
- R9: Command bit 2 = write, bit 1 = read, bit 0 = link scan. A command launches only on a 0-to-1 change of a command bit while the block is idle. Rewriting a bit that is already set, or writing while busy, starts nothing. When several bits rise together, write wins over read, and read wins over scan.
- R10: A scan repeatedly reads register 1 of the addressed PHY for as long as command bit 0 stays set, and busy stays high between reads. Status bit 2 (invalid) is set when a scan is launched and clears when the first scan read completes. Status bit 0 (link fail) is the inverse of bit 2 of the latest scan result. Once bit 0 is cleared, the frame in progress finishes and no further frames start.
- R11: Word addresses are: 0 mode, 1 command, 2 address, 3 transmit data, 4 receive data, 5 status. The read port returns the word at reg_addr one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 3 | Host word address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Registered host read data |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO line as seen at the pad |

## Verification
The assertions assume that a PHY drives the line only while the master has released it. They also assume that host writes arrive as single-cycle strobes with a stable address and data. The bench PHY model drives the line only from the second turnaround bit of a read to the last data bit. It changes its value on MDC falling edges, so the value is steady when the master samples on the rising edge. The host tasks assert reg_wr for exactly one clock and change address and data only between clock edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // host word indices
  localparam int RA_MODE = 0;
  localparam int RA_CMD  = 1;
  localparam int RA_ADDR = 2;
  localparam int RA_TX   = 3;
  localparam int RA_RX   = 4;
  localparam int RA_STAT = 5;

  // kind of frame currently in flight
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_SCAN  = 2'd3
  } op_kind_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise,
  output logic              fall
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] lim;
  logic              term;

  assign lim  = (half == '0) ? HALF_W'(1) : half;
  assign term = (cnt >= lim - HALF_W'(1));
  assign rise = term & ~mdc;
  assign fall = term & mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (term) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + HALF_W'(1);
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_read,
  input  logic              nopre,
  input  logic [AW-1:0]     phy,
  input  logic [AW-1:0]     regn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fall,
  input  logic              rise,
  input  logic              din,
  output logic              dout,
  output logic              doe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int HDR = 4 + 2 * AW;          // start, opcode, two addresses
  localparam int FRM = HDR + 2 + DATA_W;    // plus turnaround and data
  localparam int CW  = $clog2(FRM + 1);
  localparam int PW  = $clog2(PRE_LEN + 1);
  localparam logic [CW-1:0] K_HDR  = CW'(HDR);
  localparam logic [CW-1:0] K_DATA = CW'(HDR + 2);
  localparam logic [CW-1:0] K_END  = CW'(FRM);

  logic [FRM-1:0] sh;
  logic [PW-1:0]  pre_left;
  logic [CW-1:0]  bit_idx;
  logic           rdmode;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      pre_left <= '0;
      bit_idx  <= '0;
      rdmode   <= 1'b0;
      dout     <= 1'b0;
      doe      <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          rdmode   <= is_read;
          sh       <= {2'b01, (is_read ? 2'b10 : 2'b01), phy, regn,
                       (is_read ? 2'b11 : 2'b10),
                       (is_read ? {DATA_W{1'b1}} : wdata)};
          pre_left <= nopre ? '0 : PW'(PRE_LEN);
          bit_idx  <= '0;
        end
      end else if (fall) begin
        if (pre_left != '0) begin
          dout     <= 1'b1;
          doe      <= 1'b1;
          pre_left <= pre_left - PW'(1);
        end else if (bit_idx != K_END) begin
          dout    <= sh[FRM-1];
          sh      <= {sh[FRM-2:0], 1'b0};
          doe     <= !(rdmode && (bit_idx >= K_HDR));
          bit_idx <= bit_idx + CW'(1);
        end else begin
          dout <= 1'b0;
          doe  <= 1'b0;
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (rise && rdmode && (bit_idx > K_DATA)) begin
        rdata <= {rdata[DATA_W-2:0], din};
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int            HOST_W  = 32,
  parameter int            ADDR_W  = 3,
  parameter int            DIV_W   = 8,
  parameter int            PHY_AW  = 5,
  parameter int            DATA_W  = 16,
  parameter int            PRE_LEN = 32,
  parameter int            REG_LSB = 8,
  parameter int            LINK_BIT = 2,
  parameter logic [7:0]    DIV_RST = 8'd20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [HOST_W-1:0] reg_wdata,
  output logic [HOST_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  import mdio_pkg::*;

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(RA_MODE);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(RA_CMD);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(RA_ADDR);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(RA_TX);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(RA_RX);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(RA_STAT);
  localparam logic [PHY_AW-1:0] LINK_REG = PHY_AW'(1);

  logic [DIV_W-1:0]  mode_div;
  logic              mode_nopre;
  logic [2:0]        cmd_q;
  logic [PHY_AW-1:0] phy_q, regn_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic              link_fail, invalid, scan_act;
  op_kind_t          cur_kind;

  logic              rise, fall;
  logic              eng_busy, eng_done, eng_start, eng_read;
  logic [PHY_AW-1:0] eng_reg;
  logic [DATA_W-1:0] eng_rdata;
  logic [2:0]        fresh;
  logic              busy_s, go_wr, go_rd, go_scan, rescan;
  logic              wdata_unused;

  assign wdata_unused = ^reg_wdata[HOST_W-1:DATA_W];

  mdio_clkdiv #(.HALF_W(DIV_W-1)) u_div (
    .clk(clk), .rst(rst), .half(mode_div[DIV_W-1:1]),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  // launch decision: fresh bits only, idle only, write > read > scan
  always_comb begin
    fresh     = (reg_wr && reg_addr == A_CMD) ? (reg_wdata[2:0] & ~cmd_q) : 3'b000;
    busy_s    = eng_busy | scan_act;
    go_wr     = fresh[2] & ~busy_s;
    go_rd     = fresh[1] & ~fresh[2] & ~busy_s;
    go_scan   = fresh[0] & ~(|fresh[2:1]) & ~busy_s;
    rescan    = scan_act & eng_done & cmd_q[0];
    eng_start = go_wr | go_rd | go_scan | rescan;
    eng_read  = ~go_wr;
    eng_reg   = (go_scan | rescan) ? LINK_REG : regn_q;
  end

  mdio_frame #(.PRE_LEN(PRE_LEN), .AW(PHY_AW), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst(rst), .start(eng_start), .is_read(eng_read),
    .nopre(mode_nopre), .phy(phy_q), .regn(eng_reg), .wdata(tx_q),
    .fall(fall), .rise(rise), .din(mdio_in),
    .dout(mdio_out), .doe(mdio_oe), .busy(eng_busy), .done(eng_done),
    .rdata(eng_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_div   <= DIV_W'(DIV_RST);
      mode_nopre <= 1'b0;
      cmd_q      <= 3'b000;
      phy_q      <= '0;
      regn_q     <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
      link_fail  <= 1'b0;
      invalid    <= 1'b0;
      scan_act   <= 1'b0;
      cur_kind   <= OP_IDLE;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_MODE: {mode_nopre, mode_div} <= reg_wdata[DIV_W:0];
          A_CMD:  cmd_q <= reg_wdata[2:0];
          A_ADDR: begin
            phy_q  <= reg_wdata[PHY_AW-1:0];
            regn_q <= reg_wdata[REG_LSB+PHY_AW-1:REG_LSB];
          end
          A_TX:   tx_q <= reg_wdata[DATA_W-1:0];
          default: ;
        endcase
      end
      if (go_wr) cur_kind <= OP_WRITE;
      if (go_rd) cur_kind <= OP_READ;
      if (go_scan) begin
        cur_kind <= OP_SCAN;
        scan_act <= 1'b1;
        invalid  <= 1'b1;
      end
      if (eng_done) begin
        if (cur_kind == OP_READ) rx_q <= eng_rdata;
        if (cur_kind == OP_SCAN) begin
          link_fail <= ~eng_rdata[LINK_BIT];
          invalid   <= 1'b0;
          if (!cmd_q[0]) scan_act <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_MODE:  reg_rdata <= HOST_W'({mode_nopre, mode_div});
        A_CMD:   reg_rdata <= HOST_W'(cmd_q);
        A_ADDR:  reg_rdata <= HOST_W'({regn_q, {(REG_LSB-PHY_AW){1'b0}}, phy_q});
        A_TX:    reg_rdata <= HOST_W'(tx_q);
        A_RX:    reg_rdata <= HOST_W'(rx_q);
        A_STAT:  reg_rdata <= HOST_W'({invalid, busy_s, link_fail});
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HOST_W = 32,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 mdc,
  input logic                 mdio_out,
  input logic                 mdio_oe,
  input logic                 reg_wr,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [HOST_W-1:0]    reg_wdata,
  input logic [2:0]           cmd_q,
  input logic                 eng_busy,
  input logic                 eng_done,
  input logic                 scan_act,
  input logic                 invalid,
  input logic [DATA_W-1:0]    rx_q,
  input mdio_pkg::op_kind_t   cur_kind
);
  import mdio_pkg::*;

  // R7
  out_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(mdc) |-> ($stable(mdio_out) && $stable(mdio_oe)));

  // R5
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> !mdio_oe);

  // R8
  busy_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(RA_CMD) && reg_wdata[2] && !cmd_q[2]
     && !eng_busy && !scan_act) |=> eng_busy);

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_q) |-> $past(eng_done && cur_kind == OP_READ));

  // R10
  invalid_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(invalid) |-> $past(eng_done && cur_kind == OP_SCAN));
endmodule

bind mdio_master mdio_master_chk #(.HOST_W(HOST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .cmd_q(cmd_q),
  .eng_busy(eng_busy), .eng_done(eng_done), .scan_act(scan_act),
  .invalid(invalid), .rx_q(rx_q), .cur_kind(cur_kind)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in;

  logic        phy_en = 1'b0;
  logic        phy_bit = 1'b1;
  logic        line;
  assign line    = mdio_oe ? mdio_out : (phy_en ? phy_bit : 1'b1);
  assign mdio_in = line;

  always #4 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  int total = 0;
  int bad   = 0;

  // ---------------- PHY model ----------------
  logic [15:0] phy_mem [0:31];
  logic        in_frame = 1'b0;
  logic        rd_mode  = 1'b0;
  int          cnt = 0;
  int          pre_cnt = 0;
  logic [13:0] hdr;
  logic [1:0]  ta;
  logic [15:0] dat, rd_word;
  int          frames = 0;
  int          cap_pre;
  logic [1:0]  cap_st, cap_op, cap_ta;
  logic [4:0]  cap_phy, cap_reg;
  logic [15:0] cap_dat;

  initial begin
    for (int r = 0; r < 32; r++) phy_mem[r] = 16'(r * 257) ^ 16'h5A5A;
  end

  initial forever begin
    @(posedge mdc);
    if (!in_frame) begin
      if (!mdio_oe) pre_cnt = 0;
      else if (line) pre_cnt++;
      else begin
        in_frame = 1'b1; cnt = 1; hdr = 14'd0; cap_pre = pre_cnt; pre_cnt = 0;
      end
    end else begin
      cnt++;
      if (cnt <= 14) hdr = {hdr[12:0], line};
      else if (cnt <= 16) ta = {ta[0], line};
      else dat = {dat[14:0], line};
      if (cnt == 14) begin
        rd_mode = (hdr[11:10] == 2'b10);
        rd_word = phy_mem[hdr[4:0]];
      end
      if (cnt == 32) begin
        cap_st = hdr[13:12]; cap_op = hdr[11:10]; cap_phy = hdr[9:5];
        cap_reg = hdr[4:0]; cap_ta = ta; cap_dat = dat;
        if (hdr[11:10] == 2'b01) phy_mem[hdr[4:0]] = dat;
        in_frame = 1'b0; rd_mode = 1'b0; frames++;
      end
    end
  end

  initial forever begin
    @(negedge mdc);
    if (in_frame && rd_mode && cnt >= 15 && cnt <= 31) begin
      phy_en  = 1'b1;
      phy_bit = (cnt == 15) ? 1'b0 : rd_word[31-cnt];
    end else begin
      phy_en = 1'b0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      host_read(3'd5, s);
      if (!s[1]) return;
    end
    chk("R8 busy never dropped", s, 32'd0);
  endtask

  task automatic wait_frames(input int target);
    for (int i = 0; i < 20000 && frames < target; i++) @(negedge clk);
  endtask

  task automatic mdc_period(output int p);
    logic prev;
    int   edges;
    p = 0; edges = 0; prev = mdc;
    while (edges < 2) begin
      @(negedge clk);
      if (edges == 1) p++;
      if (mdc && !prev) edges++;
      prev = mdc;
    end
  endtask

  // wr, nopre, div[7:0], phy[4:0], reg[4:0], data[15:0]
  localparam logic [35:0] VEC [0:6] = '{
    {1'b1, 1'b0, 8'd6, 5'd3,  5'd4,  16'hBEEF},
    {1'b0, 1'b0, 8'd6, 5'd3,  5'd4,  16'h0000},
    {1'b0, 1'b1, 8'd7, 5'd31, 5'd31, 16'h0000},
    {1'b1, 1'b1, 8'd4, 5'd16, 5'd0,  16'h0001},
    {1'b0, 1'b0, 8'd2, 5'd10, 5'd21, 16'h0000},
    {1'b1, 1'b0, 8'd3, 5'd1,  5'd30, 16'h8000},
    {1'b0, 1'b1, 8'd9, 5'd0,  5'd30, 16'h0000}
  };

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int          p, f0;
    logic [15:0] exp;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 / R11 reset state
    host_read(3'd0, rv); chk("R1 mode reset", rv, 32'd20);
    host_read(3'd1, rv); chk("R1 command reset", rv, 32'd0);
    host_read(3'd5, rv); chk("R1 status reset", rv, 32'd0);
    host_read(3'd4, rv); chk("R1 rx reset", rv, 32'd0);
    chk("R1 mdio released", {31'd0, mdio_oe}, 32'd0);
    mdc_period(p); chk("R2 default period", p, 32'd20);

    // R2 divider evenness
    host_write(3'd0, 32'd7); repeat (40) @(negedge clk);
    mdc_period(p); chk("R2 odd divider 7", p, 32'd6);
    host_write(3'd0, 32'd6); repeat (40) @(negedge clk);
    mdc_period(p); chk("R2 divider 6", p, 32'd6);
    host_write(3'd0, 32'd1); repeat (40) @(negedge clk);
    mdc_period(p); chk("R2 divider 1 floors", p, 32'd2);

    // table of frames: R3 R4 R5 R6 R8
    for (int v = 0; v < 7; v++) begin
      logic [35:0] t;
      t = VEC[v];
      host_write(3'd0, {23'd0, t[34], t[33:26]});
      host_write(3'd2, {19'd0, t[20:16], 3'd0, t[25:21]});
      if (t[35]) host_write(3'd3, {16'd0, t[15:0]});
      exp = phy_mem[t[20:16]];
      f0 = frames;
      host_write(3'd1, t[35] ? 32'd4 : 32'd2);
      host_read(3'd5, rv); chk("R8 busy after launch", {31'd0, rv[1]}, 32'd1);
      wait_idle();
      chk("R3 one frame", frames, f0 + 1);
      chk("R3 start code", {30'd0, cap_st}, 32'd1);
      chk("R3 opcode", {30'd0, cap_op}, t[35] ? 32'd1 : 32'd2);
      chk("R3 phy addr", {27'd0, cap_phy}, {27'd0, t[25:21]});
      chk("R3 reg addr", {27'd0, cap_reg}, {27'd0, t[20:16]});
      chk("R4 preamble length", cap_pre, t[34] ? 32'd0 : 32'd32);
      if (t[35]) begin
        chk("R5 turnaround", {30'd0, cap_ta}, 32'd2);
        chk("R5 data written", {16'd0, phy_mem[t[20:16]]}, {16'd0, t[15:0]});
      end else begin
        host_read(3'd4, rv); chk("R6 read data", rv, {16'd0, exp});
      end
      chk("R5 released after frame", {31'd0, mdio_oe}, 32'd0);
      host_write(3'd1, 32'd0);
    end

    // R9 no relaunch without a fresh bit
    host_write(3'd0, 32'd6);
    host_write(3'd2, {19'd0, 5'd2, 3'd0, 5'd5});
    f0 = frames;
    host_write(3'd1, 32'd2); wait_idle();
    host_write(3'd1, 32'd2); repeat (600) @(negedge clk);
    chk("R9 held bit no relaunch", frames, f0 + 1);
    host_read(3'd5, rv); chk("R9 idle after held bit", rv, 32'd0);
    host_read(3'd4, rv); chk("R6 rx holds", rv, {16'd0, phy_mem[2]});
    host_write(3'd1, 32'd0); host_write(3'd1, 32'd2); wait_idle();
    chk("R9 fresh bit relaunches", frames, f0 + 2);
    host_write(3'd1, 32'd0);

    // R9 command while busy ignored
    host_write(3'd3, 32'h0000_1357);
    f0 = frames;
    host_write(3'd1, 32'd4); host_write(3'd1, 32'd6);
    wait_idle(); repeat (600) @(negedge clk);
    chk("R9 busy write ignored", frames, f0 + 1);
    chk("R9 busy write op", {30'd0, cap_op}, 32'd1);
    host_write(3'd1, 32'd0);

    // R9 priority write over read over scan
    host_write(3'd3, 32'h0000_2468);
    f0 = frames;
    host_write(3'd1, 32'd7); wait_idle(); repeat (600) @(negedge clk);
    chk("R9 priority single frame", frames, f0 + 1);
    chk("R9 priority picks write", {30'd0, cap_op}, 32'd1);
    host_read(3'd5, rv); chk("R9 no scan started", rv, 32'd0);
    host_write(3'd1, 32'd0);

    // R10 scan
    phy_mem[1] = 16'h0004;
    host_write(3'd2, {19'd0, 5'd9, 3'd0, 5'd3});
    f0 = frames;
    host_write(3'd1, 32'd1);
    host_read(3'd5, rv); chk("R10 invalid and busy at start", rv, 32'd6);
    wait_frames(f0 + 1); repeat (30) @(negedge clk);
    host_read(3'd5, rv); chk("R10 link up, still busy", rv, 32'd2);
    chk("R10 scan reads reg 1", {27'd0, cap_reg}, 32'd1);
    chk("R10 scan opcode read", {30'd0, cap_op}, 32'd2);
    phy_mem[1] = 16'hFFFB;
    wait_frames(frames + 2); repeat (30) @(negedge clk);
    host_read(3'd5, rv); chk("R10 link fail reported", rv, 32'd3);
    host_write(3'd1, 32'd0); wait_idle();
    f0 = frames;
    repeat (800) @(negedge clk);
    chk("R10 scan stops", frames, f0);
    host_read(3'd5, rv); chk("R10 status after stop", rv, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule